// File: doc/BRIEF.md
# Strobe-Latched SRAM Read Sequencer

This block runs read cycles on an asynchronous static RAM that captures its address on the high-to-low edge of an active-low enable strobe. A host asks for a read by presenting an address together with a one-cycle start pulse. The sequencer then drives the address with the enable strobe still high for a set number of setup cycles. It pulls enable low to latch the address and keeps the address steady for a hold window. It waits out the access time and samples the RAM data bus, then raises enable again. Before a new cycle may begin, enable stays high for a precharge window.

Each phase length is a parameter counted in clock cycles, with a minimum of one. Once the hold window has passed, the sequencer stops holding the address and lets the memory address bus follow the host's address input, one register later. This means the next address can already be on the bus while the current access and precharge finish. The sampled word comes back on a registered data output with a one-cycle done pulse. A busy output tells the host that start requests are ignored until the sequencer is idle again. The write strobe is never pulled low.

Top module: `strobe_read_seq`

## Requirements
- R1: While reset is held and in the cycle after it is released, mem_en_n and mem_wr_n are 1, mem_addr is 0, busy is 0 and rsp_valid is 0.
- R2: A req_start sampled high while idle loads req_addr onto mem_addr at that edge. mem_en_n then stays 1 for exactly SETUP_CYC cycles before it falls, and mem_addr does not change during that time.
- R3: mem_addr keeps the latched address for at least HOLD_CYC cycles after mem_en_n falls.
- R4: HOLD_CYC+1 cycles after mem_en_n falls, and from then until the sequencer is idle, mem_addr shows the req_addr value from the previous cycle. This change does not alter the word returned for the current access.
- R5: mem_en_n stays low for exactly ACCESS_CYC cycles. The word on mem_data at the edge where it rises is the one returned.
- R6: rsp_valid is 1 for exactly one cycle, starting at the edge where mem_en_n rises. rsp_data then holds the sampled word and keeps it until the next pulse.
- R7: After mem_en_n rises, it stays 1 for at least PRECH_CYC cycles. busy is 1 from the edge that accepts a start until PRECH_CYC cycles after mem_en_n rises, and then returns to 0.
- R8: A req_start seen while busy is 1 starts no cycle, and no extra enable fall or rsp_valid pulse appears.
- R9: mem_wr_n is 1 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_start | input | 1 | Start a read; accepted only while busy is 0 |
| req_addr | input | ADDR_W | Address for the read; mirrored on the bus after the hold window |
| busy | output | 1 | A cycle or its precharge is in progress |
| rsp_valid | output | 1 | One-cycle done pulse |
| rsp_data | output | DATA_W | Word sampled from the RAM |
| mem_en_n | output | 1 | Active-low enable strobe; its falling edge latches the address |
| mem_wr_n | output | 1 | Active-low write strobe, held high |
| mem_addr | output | ADDR_W | RAM address bus |
| mem_data | input | DATA_W | RAM data bus, high impedance while enable is high |

## Verification
The bench's RAM model latches the address on the enable fall. It then drives unknowns until just before the access time runs out, and floats the bus while enable is high. A sequencer that samples early therefore returns garbage, and one that drops enable early never sees valid data. During each access the host address is switched to an unrelated value. A design that let go of the address inside the hold window trips the hold-time monitor. A design that never let go fails the look-ahead check. Start pulses held through the whole access show whether a busy sequencer starts a second cycle. The back-to-back reads check the precharge gap and the one-cycle width of the done pulse.

// File: rtl/srs_pkg.sv
// Shared types and helpers for the strobe-latched read sequencer.
package srs_pkg;

    // The four phases of one read cycle
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,   // enable high, waiting for a request
        PH_SETUP  = 2'd1,   // address driven, enable still high
        PH_ACCESS = 2'd2,   // enable low, waiting for valid data
        PH_PRECH  = 2'd3    // enable high again, RAM recovers
    } phase_t;

    // Largest of three interval lengths
    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/srs_interval.sv
// Phase interval counter.
// Counts clock cycles within the current phase. It restarts from zero when the
// phase controller changes phase. Assumes limit >= 1.
module srs_interval #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] count,
    output logic             last
);

    // Final cycle of the current phase
    assign last = (count == limit - 1'b1);

    // Cycle counter, cleared on each phase change
    always_ff @(posedge clk) begin
        if (!rst_n)       count <= '0;
        else if (restart) count <= '0;
        else if (!last)   count <= count + 1'b1;
    end

    // The count never passes the final cycle of its phase
    p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && last) |=> (count == $past(count) || count == '0));

endmodule

// File: rtl/srs_phase_fsm.sv
// Read-cycle phase controller.
// Moves through idle, setup, access and precharge, and takes the length of each
// phase from the interval counter. Assumes every phase length is at least 1.
module srs_phase_fsm
    import srs_pkg::*;
#(
    parameter int CNT_W      = 3,
    parameter int SETUP_CYC  = 2,
    parameter int ACCESS_CYC = 4,
    parameter int PRECH_CYC  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             last,
    output phase_t           phase,
    output phase_t           phase_nxt,
    output logic             restart,
    output logic [CNT_W-1:0] limit,
    output logic             sample
);

    localparam logic [CNT_W-1:0] L_SETUP  = CNT_W'(SETUP_CYC);
    localparam logic [CNT_W-1:0] L_ACCESS = CNT_W'(ACCESS_CYC);
    localparam logic [CNT_W-1:0] L_PRECH  = CNT_W'(PRECH_CYC);

    // Phase length for the counter
    always_comb begin
        unique case (phase)
            PH_SETUP:  limit = L_SETUP;
            PH_ACCESS: limit = L_ACCESS;
            PH_PRECH:  limit = L_PRECH;
            default:   limit = CNT_W'(1);
        endcase
    end

    // Next-phase decision
    always_comb begin
        phase_nxt = phase;
        unique case (phase)
            PH_IDLE:   if (start) phase_nxt = PH_SETUP;
            PH_SETUP:  if (last)  phase_nxt = PH_ACCESS;
            PH_ACCESS: if (last)  phase_nxt = PH_PRECH;
            PH_PRECH:  if (last)  phase_nxt = PH_IDLE;
            default:              phase_nxt = PH_IDLE;
        endcase
    end

    assign restart = (phase_nxt != phase);
    assign sample  = (phase == PH_ACCESS) && last;

    // Phase register
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_IDLE;
        else        phase <= phase_nxt;
    end

    // A start during precharge does not cut the precharge short
    p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_PRECH && !last) |=> (phase == PH_PRECH));

    // Only the idle phase can lead into setup
    p_setup_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SETUP && $past(phase) != PH_SETUP) |-> ($past(phase) == PH_IDLE));

endmodule

// File: rtl/srs_bus_drive.sv
// Memory-side strobe and address driver.
// Registers the enable strobe from the next phase, so it changes on the same edge
// as the phase register. It holds the latched address through setup and the hold
// window, then lets the bus follow the host address. Assumes HOLD_CYC <= ACCESS_CYC.
module srs_bus_drive
    import srs_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int CNT_W    = 3,
    parameter int HOLD_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_t            phase,
    input  phase_t            phase_nxt,
    input  logic [CNT_W-1:0]  count,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              mem_en_n,
    output logic [ADDR_W-1:0] mem_addr
);

    localparam logic [CNT_W-1:0] L_HOLD = CNT_W'(HOLD_CYC);

    logic accept;
    logic follow;

    assign accept = (phase == PH_IDLE) && (phase_nxt == PH_SETUP);
    assign follow = ((phase == PH_ACCESS) && (count >= L_HOLD)) || (phase == PH_PRECH);

    // Enable strobe: low only during the access phase
    always_ff @(posedge clk) begin
        if (!rst_n) mem_en_n <= 1'b1;
        else        mem_en_n <= (phase_nxt != PH_ACCESS);
    end

    // Address bus: load on accept, track the host once the hold window has passed
    always_ff @(posedge clk) begin
        if (!rst_n)                mem_addr <= '0;
        else if (accept || follow) mem_addr <= req_addr;
    end

    // Enable is low only in the access phase
    p_en_low_access_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_ACCESS) |-> mem_en_n);

    // Address is steady through setup
    p_setup_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SETUP && count != '0) |-> $stable(mem_addr));

    // Address is steady through the hold window
    p_hold_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_ACCESS && count <= L_HOLD) |-> $stable(mem_addr));

    // Enable rises only into precharge
    p_rise_prech_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_en_n) |-> (phase == PH_PRECH));

endmodule

// File: rtl/srs_capture.sv
// Read data capture.
// Registers the RAM data bus on the sample strobe and raises a one-cycle done flag.
// Assumes the sample strobe is never high two cycles in a row.
module srs_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample,
    input  logic [DATA_W-1:0] mem_data,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);

    logic armed;

    // Marks the cycles after reset release, for the stability check
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // Data register and done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= sample;
            if (sample) rsp_data <= mem_data;
        end
    end

    // The done pulse lasts one cycle
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // Returned data changes only together with a done pulse
    p_data_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !rsp_valid) |-> $stable(rsp_data));

endmodule

// File: rtl/strobe_read_seq.sv
// Strobe-latched SRAM read sequencer (top).
// Runs one read cycle per accepted start: setup, enable fall, access, sample,
// enable rise and precharge. Phase lengths are in clock cycles, each at least 1,
// and HOLD_CYC must not exceed ACCESS_CYC. The write strobe is held high.
module strobe_read_seq
    import srs_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 8,
    parameter int SETUP_CYC  = 2,
    parameter int HOLD_CYC   = 2,
    parameter int ACCESS_CYC = 4,
    parameter int PRECH_CYC  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_start,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              busy,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              mem_en_n,
    output logic              mem_wr_n,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_data
);

    localparam int MAX_CYC = int'(max3(SETUP_CYC, ACCESS_CYC, PRECH_CYC));
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    phase_t           phase;
    phase_t           phase_nxt;
    logic             restart;
    logic             last;
    logic             sample;
    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] count;

    assign busy     = (phase != PH_IDLE);
    assign mem_wr_n = 1'b1;

    srs_phase_fsm #(
        .CNT_W      (CNT_W),
        .SETUP_CYC  (SETUP_CYC),
        .ACCESS_CYC (ACCESS_CYC),
        .PRECH_CYC  (PRECH_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (req_start),
        .last      (last),
        .phase     (phase),
        .phase_nxt (phase_nxt),
        .restart   (restart),
        .limit     (limit),
        .sample    (sample)
    );

    srs_interval #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .limit   (limit),
        .count   (count),
        .last    (last)
    );

    srs_bus_drive #(
        .ADDR_W   (ADDR_W),
        .CNT_W    (CNT_W),
        .HOLD_CYC (HOLD_CYC)
    ) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase     (phase),
        .phase_nxt (phase_nxt),
        .count     (count),
        .req_addr  (req_addr),
        .mem_en_n  (mem_en_n),
        .mem_addr  (mem_addr)
    );

    srs_capture #(
        .DATA_W (DATA_W)
    ) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample    (sample),
        .mem_data  (mem_data),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data)
    );

    // The done pulse comes on the edge where enable rises
    p_done_at_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $rose(mem_en_n));

    // Write strobe stays inactive
    p_write_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_n);

    // Enable falls only while a cycle is in progress
    p_fall_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_en_n) |-> busy);

endmodule

// File: tb/sim_strobe_read_seq.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes expected words and a monitor compares them
// against each done pulse. A RAM model checks the address timing.
module sim_strobe_read_seq;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 8;
    localparam int TS     = 2;
    localparam int TH     = 2;
    localparam int TA     = 4;
    localparam int TP     = 3;
    localparam real PER   = 5.0;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_start = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              busy;
    logic              rsp_valid;
    logic [DATA_W-1:0] rsp_data;
    logic              mem_en_n;
    logic              mem_wr_n;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] ram_q = 'z;

    int checks = 0;
    int errors = 0;
    int reads  = 0;
    int falls  = 0;
    int wr_bad = 0;
    logic [DATA_W-1:0] sb_q[$];
    logic [DATA_W-1:0] last_data = '0;
    realtime t_addr = 0.0;
    realtime t_fall = 0.0;
    realtime t_rise = -1000.0;

    always #2.5 clk = ~clk;

    strobe_read_seq #(
        .ADDR_W (ADDR_W), .DATA_W (DATA_W), .SETUP_CYC (TS),
        .HOLD_CYC (TH), .ACCESS_CYC (TA), .PRECH_CYC (TP)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .req_start (req_start), .req_addr (req_addr),
        .busy (busy), .rsp_valid (rsp_valid), .rsp_data (rsp_data),
        .mem_en_n (mem_en_n), .mem_wr_n (mem_wr_n), .mem_addr (mem_addr),
        .mem_data (ram_q)
    );

    function automatic logic [DATA_W-1:0] word_of(input logic [ADDR_W-1:0] a);
        return DATA_W'((a * 8'h3b) ^ (a >> 5) ^ 8'ha5);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // RAM model: latch on enable fall, unknown until the access time, float when high
    always @(negedge mem_en_n) begin
        logic [ADDR_W-1:0] lat;
        lat = mem_addr;
        falls++;
        t_fall = $realtime;
        chk(($realtime - t_addr) >= TS * PER - 0.1, "R2 setup time", int'($realtime - t_addr), TS * 5);
        chk(($realtime - t_rise) >= TP * PER - 0.1, "R7 precharge gap", int'($realtime - t_rise), TP * 5);
        ram_q = 'x;
        #(TA * PER - 2.0);
        if (!mem_en_n) ram_q = word_of(lat);
    end

    always @(posedge mem_en_n) begin
        t_rise = $realtime;
        ram_q = 'z;
    end

    // Hold-time monitor on the address bus
    always @(mem_addr) begin
        t_addr = $realtime;
        if (rst_n && !mem_en_n)
            chk(($realtime - t_fall) > TH * PER - 0.1, "R3 hold time", int'($realtime - t_fall), TH * 5);
    end

    // Scoreboard monitor and write-strobe watch
    always @(negedge clk) begin
        if (mem_wr_n !== 1'b1) wr_bad++;
        if (rst_n && rsp_valid) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "R8 unexpected response", int'(rsp_data), 0);
            end else begin
                logic [DATA_W-1:0] e;
                e = sb_q.pop_front();
                chk(rsp_data === e, "R5 sampled data", int'(rsp_data), int'(e));
            end
            last_data = rsp_data;
        end else if (rst_n && rsp_data !== last_data) begin
            chk(1'b0, "R6 data stable", int'(rsp_data), int'(last_data));
            last_data = rsp_data;
        end
    end

    // One read with host address switched to junk after the start; poke holds start high
    task automatic run_read(input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] junk,
                            input bit poke);
        @(negedge clk);
        req_addr  = a;
        req_start = 1'b1;
        sb_q.push_back(word_of(a));
        reads++;
        @(negedge clk);
        req_start = poke;
        req_addr  = junk;
        chk(busy === 1'b1, "R7 busy after accept", int'(busy), 1);
        chk(mem_addr === a, "R2 address loaded", int'(mem_addr), int'(a));
        repeat (TS - 1) @(negedge clk);
        chk(mem_en_n === 1'b1, "R2 enable high in setup", int'(mem_en_n), 1);
        @(negedge clk);
        chk(mem_en_n === 1'b0, "R5 enable fall", int'(mem_en_n), 0);
        repeat (TH) @(negedge clk);
        chk(mem_addr === a, "R3 address held", int'(mem_addr), int'(a));
        @(negedge clk);
        chk(mem_addr === junk, "R4 address follows host", int'(mem_addr), int'(junk));
        repeat (TA - TH - 2) @(negedge clk);
        chk(mem_en_n === 1'b0, "R5 enable low until access end", int'(mem_en_n), 0);
        @(negedge clk);
        req_start = 1'b0;
        chk(mem_en_n === 1'b1, "R5 enable rise", int'(mem_en_n), 1);
        chk(rsp_valid === 1'b1, "R6 done pulse", int'(rsp_valid), 1);
        @(negedge clk);
        chk(rsp_valid === 1'b0, "R6 pulse width", int'(rsp_valid), 0);
        repeat (TP - 2) @(negedge clk);
        chk(busy === 1'b1, "R7 busy in precharge", int'(busy), 1);
        @(negedge clk);
        chk(busy === 1'b0, "R7 idle after precharge", int'(busy), 0);
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(mem_en_n === 1'b1 && mem_wr_n === 1'b1, "R1 strobes in reset", int'({mem_en_n, mem_wr_n}), 3);
        chk(mem_addr === '0 && busy === 1'b0 && rsp_valid === 1'b0, "R1 outputs in reset",
            int'(mem_addr), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 1'b0 && mem_en_n === 1'b1 && rsp_valid === 1'b0, "R1 after release",
            int'({busy, mem_en_n, rsp_valid}), 2);
        run_read(12'h000, 12'hfff, 1'b0);
        run_read(12'hfff, 12'h000, 1'b1);
        run_read(12'h5a5, 12'h5a5, 1'b0);
        for (int i = 0; i < 8; i++)
            run_read(ADDR_W'(i * 397 + 17), ADDR_W'(i * 1231 + 3), 1'(i % 2));
        repeat (10) @(negedge clk);
        chk(sb_q.size() == 0, "R6 all responses seen", sb_q.size(), 0);
        chk(falls == reads, "R8 one enable fall per accepted start", falls, reads);
        chk(wr_bad == 0, "R9 write strobe high", wr_bad, 0);
        report();
    end

    initial begin
        #(200000 * 5.0);
        chk(1'b0, "watchdog", 0, 1);
        report();
    end

endmodule